// File: doc/BRIEF.md
# Firmware Window Decoder and Serial Flash Read Bridge

This block receives 32-bit memory read requests through a valid/ready handshake. The top address bits are compared against fixed boundaries, and each request is sorted into one of five regions: low RAM, the legacy area, high RAM, memory-mapped I/O or the firmware window. The region code appears combinationally in the same cycle as the address.

A request that hits the firmware window becomes a read transaction on a four-wire SPI master port in mode 0. The bridge lowers chip select and sends the read opcode 0x03, followed by the low 24 address bits. It then clocks in the requested number of bytes and releases chip select. The returned bytes are packed little-endian into a 64-bit word and presented with a one-cycle valid pulse. A request to any other region is accepted, reports only its region code and causes no serial activity.

The serial clock is derived from the system clock. Each half period of the serial clock lasts `SCLK_HALF_CYC` system cycles.

Top module: `fw_flash_bridge`

## Requirements
- R1: `region` encodes the address as follows: 0 for 0x00000000..0x0009FFFF, 1 for 0x000A0000..0x000FFFFF, 2 for 0x00100000..0xBFFFFFFF, 3 for 0xC0000000..0xFEFFFFFF and 4 for 0xFF000000..0xFFFFFFFF.
- R2: `region` follows `req_addr` combinationally in the same cycle, whatever the value of `req_valid`.
- R3: An accepted request with region 4 lowers `spi_cs_n`. MOSI then carries the byte 0x03 followed by address bits 23:0, most significant byte first and most significant bit first (so 0xFFFFFFF0 sends 03 FF FF F0).
- R4: The serial link runs in SPI mode 0. `spi_sclk` is low whenever `spi_cs_n` is high, and MOSI does not change while `spi_sclk` is high. Each serial clock phase lasts `SCLK_HALF_CYC` system cycles, so chip select stays low for 2*`SCLK_HALF_CYC`*(32+8*N) cycles.
- R5: The transaction gives exactly 32+8*N rising edges on `spi_sclk`, where N = `req_len` for values 1..8. A length of 0 reads 1 byte, and a length above 8 reads 8 bytes.
- R6: The first data byte received goes to `rsp_data[7:0]`, the second to `rsp_data[15:8]`, and so on upward. Within each byte, bits arrive MSB first. Bytes that are not read are zero.
- R7: `req_ready` is low from the cycle after a firmware request is accepted until after the response. `rsp_valid` is a single-cycle pulse in the cycle in which `spi_cs_n` returns high.
- R8: A request to regions 0..3 is accepted with `req_ready` staying high. It causes no chip-select activity, no serial clock edge and no `rsp_valid`.
- R9: Between two transactions, `spi_cs_n` stays high for at least 2*`SCLK_HALF_CYC` system cycles (one serial clock period).
- R10: During reset, `req_ready`=1, `spi_cs_n`=1, `spi_sclk`=0 and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Bridge can accept a request |
| req_addr | input | 32 | Request byte address |
| req_len | input | 4 | Bytes to read, 1..8 |
| region | output | 3 | Region code of `req_addr` |
| rsp_valid | output | 1 | One-cycle pulse when read data is valid |
| rsp_data | output | 64 | Little-endian packed read data |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The decoder is swept over all 4096 values of the top 12 address bits, with scrambled low bits. The exact edges on both sides of every boundary are also tried, which separates the off-by-one and comparison-direction faults.

Firmware reads sweep every length from 1 to 8 at the reset-vector address, together with the out-of-range lengths 0 and 12. A hand-written flash model returns bytes that are a function of their address. Any swap of byte order, bit order, length or address fields therefore gives a different word, opcode or edge count.

Back-to-back reads measure the chip-select idle gap. Requests to each of the other regions check that the serial port stays silent.

// File: rtl/fwb_pkg.sv
package fwb_pkg;

  typedef enum logic [2:0] {
    RGN_LOWRAM  = 3'd0,
    RGN_LEGACY  = 3'd1,
    RGN_HIGHRAM = 3'd2,
    RGN_MMIO    = 3'd3,
    RGN_FLASH   = 3'd4
  } region_e;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SHIFT = 2'd1,
    ENG_GAP   = 2'd2
  } eng_state_e;

  localparam logic [7:0] FLASH_READ_OP = 8'h03;

endpackage

// File: rtl/fwb_region_decode.sv
module fwb_region_decode
  import fwb_pkg::*;
#(
  parameter logic [31:0] LEGACY_BASE  = 32'h000A_0000,
  parameter logic [31:0] HIGHRAM_BASE = 32'h0010_0000,
  parameter logic [31:0] MMIO_BASE    = 32'hC000_0000,
  parameter logic [31:0] FLASH_BASE   = 32'hFF00_0000
) (
  input  logic [31:0] addr,
  output region_e     region
);

  // Priority from the top of the map downward: each base is an inclusive lower bound.
  always_comb begin
    if (addr >= FLASH_BASE)        region = RGN_FLASH;
    else if (addr >= MMIO_BASE)    region = RGN_MMIO;
    else if (addr >= HIGHRAM_BASE) region = RGN_HIGHRAM;
    else if (addr >= LEGACY_BASE)  region = RGN_LEGACY;
    else                           region = RGN_LOWRAM;
  end

endmodule

// File: rtl/fwb_tick_gen.sv
module fwb_tick_gen #(
  parameter int SCLK_HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int CW = (SCLK_HALF_CYC > 1) ? $clog2(SCLK_HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(SCLK_HALF_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/fwb_spi_engine.sv
module fwb_spi_engine
  import fwb_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int ADDR_BITS = 24,
  localparam int LEN_W    = $clog2(MAX_BYTES + 1),
  localparam int DATA_W   = 8 * MAX_BYTES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [ADDR_BITS-1:0] start_addr,
  input  logic [LEN_W-1:0]     start_len,
  input  logic                 tick,
  input  logic                 miso,
  output logic                 idle,
  output logic                 run,
  output logic                 sclk,
  output logic                 mosi,
  output logic                 cs_n,
  output logic                 done,
  output logic [DATA_W-1:0]    rdata
);

  localparam int HDR_BITS = 8 + ADDR_BITS;
  localparam int BIT_W    = $clog2(HDR_BITS + DATA_W + 1);
  localparam int IW       = $clog2(DATA_W);

  eng_state_e            state_q, state_d;
  logic                  sclk_q, sclk_d;
  logic                  cs_n_q, cs_n_d;
  logic [HDR_BITS-1:0]   tx_q, tx_d;
  logic [BIT_W-1:0]      bits_q, bits_d;
  logic [BIT_W-1:0]      total_q, total_d;
  logic [DATA_W-1:0]     data_q, data_d;
  logic                  done_q, done_d;
  logic                  gap_q, gap_d;

  logic [LEN_W-1:0]      nbytes;
  logic [BIT_W-1:0]      data_bit;
  logic [IW-1:0]         wr_idx;

  // Clamp the requested length into 1..MAX_BYTES.
  always_comb begin
    if (start_len == '0)                          nbytes = LEN_W'(1);
    else if (start_len > LEN_W'(MAX_BYTES))       nbytes = LEN_W'(MAX_BYTES);
    else                                          nbytes = start_len;
  end

  // Data bit k lands in byte k/8 at bit 7-(k%8): invert the low three bits.
  assign data_bit = bits_q - BIT_W'(HDR_BITS);
  assign wr_idx   = {data_bit[IW-1:3], ~data_bit[2:0]};

  always_comb begin
    state_d = state_q;
    sclk_d  = sclk_q;
    cs_n_d  = cs_n_q;
    tx_d    = tx_q;
    bits_d  = bits_q;
    total_d = total_q;
    data_d  = data_q;
    done_d  = 1'b0;
    gap_d   = gap_q;
    unique case (state_q)
      ENG_IDLE: begin
        if (start) begin
          state_d = ENG_SHIFT;
          cs_n_d  = 1'b0;
          sclk_d  = 1'b0;
          tx_d    = {FLASH_READ_OP, start_addr};
          bits_d  = '0;
          total_d = BIT_W'(HDR_BITS) + (BIT_W'(nbytes) << 3);
          data_d  = '0;
        end
      end
      ENG_SHIFT: begin
        if (tick) begin
          if (!sclk_q) begin
            sclk_d = 1'b1;
            bits_d = bits_q + 1'b1;
            if (bits_q >= BIT_W'(HDR_BITS)) data_d[wr_idx] = miso;
          end else begin
            sclk_d = 1'b0;
            if (bits_q == total_q) begin
              cs_n_d  = 1'b1;
              done_d  = 1'b1;
              gap_d   = 1'b0;
              state_d = ENG_GAP;
            end else begin
              tx_d = tx_q << 1;
            end
          end
        end
      end
      ENG_GAP: begin
        if (tick) begin
          if (gap_q) state_d = ENG_IDLE;
          else       gap_d   = 1'b1;
        end
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      tx_q    <= '0;
      bits_q  <= '0;
      total_q <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
      gap_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sclk_q  <= sclk_d;
      cs_n_q  <= cs_n_d;
      tx_q    <= tx_d;
      bits_q  <= bits_d;
      total_q <= total_d;
      data_q  <= data_d;
      done_q  <= done_d;
      gap_q   <= gap_d;
    end
  end

  assign idle  = (state_q == ENG_IDLE);
  assign run   = !idle;
  assign sclk  = sclk_q;
  assign mosi  = tx_q[HDR_BITS-1];
  assign cs_n  = cs_n_q;
  assign done  = done_q;
  assign rdata = data_q;

endmodule

// File: rtl/fw_flash_bridge.sv
module fw_flash_bridge
  import fwb_pkg::*;
#(
  parameter int MAX_BYTES     = 8,
  parameter int SCLK_HALF_CYC = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic [31:0]                    req_addr,
  input  logic [$clog2(MAX_BYTES+1)-1:0] req_len,
  output logic [2:0]                     region,
  output logic                           rsp_valid,
  output logic [8*MAX_BYTES-1:0]         rsp_data,
  output logic                           spi_sclk,
  output logic                           spi_mosi,
  input  logic                           spi_miso,
  output logic                           spi_cs_n
);

  localparam int ADDR_BITS = 24;

  region_e rgn;
  logic    eng_idle, eng_run, tick, start;

  fwb_region_decode u_decode (
    .addr   (req_addr),
    .region (rgn)
  );

  assign region    = rgn;
  assign req_ready = eng_idle;
  assign start     = req_valid && eng_idle && (rgn == RGN_FLASH);

  fwb_tick_gen #(.SCLK_HALF_CYC(SCLK_HALF_CYC)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (eng_run),
    .tick  (tick)
  );

  fwb_spi_engine #(.MAX_BYTES(MAX_BYTES), .ADDR_BITS(ADDR_BITS)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_addr (req_addr[ADDR_BITS-1:0]),
    .start_len  (req_len),
    .tick       (tick),
    .miso       (spi_miso),
    .idle       (eng_idle),
    .run        (eng_run),
    .sclk       (spi_sclk),
    .mosi       (spi_mosi),
    .cs_n       (spi_cs_n),
    .done       (rsp_valid),
    .rdata      (rsp_data)
  );

endmodule

// File: rtl/fw_flash_bridge_checks.sv
module fw_flash_bridge_checks #(
  parameter int SCLK_HALF_CYC = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic [31:0] req_addr,
  input logic [2:0]  region,
  input logic        rsp_valid,
  input logic        spi_sclk,
  input logic        spi_mosi,
  input logic        spi_cs_n
);

  localparam int GAP_MIN = 2 * SCLK_HALF_CYC;
  localparam int GW      = $clog2(GAP_MIN + 1);

  logic [GW-1:0] gap_q;

  // Cycles chip select has been high, saturating; starts satisfied at reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     gap_q <= GW'(GAP_MIN);
    else if (!spi_cs_n)             gap_q <= '0;
    else if (gap_q < GW'(GAP_MIN))  gap_q <= gap_q + 1'b1;
  end

  a_r1_flash_top_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (region == 3'd4) |-> (req_addr[31:24] == 8'hFF));

  a_r1_lowram_code: assert property (@(posedge clk) disable iff (!rst_n)
    (req_addr < 32'h000A_0000) |-> (region == 3'd0));

  a_r4_clock_idles_low: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  a_r4_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> !req_ready);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r7_pulse_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $rose(spi_cs_n));

  a_r9_cs_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (gap_q >= GW'(GAP_MIN)));

endmodule

bind fw_flash_bridge fw_flash_bridge_checks #(.SCLK_HALF_CYC(SCLK_HALF_CYC)) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .region    (region),
  .rsp_valid (rsp_valid),
  .spi_sclk  (spi_sclk),
  .spi_mosi  (spi_mosi),
  .spi_cs_n  (spi_cs_n)
);

// File: tb/fw_flash_bridge_tb_top.sv
`timescale 1ns/1ps
module fw_flash_bridge_tb_top;

  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic [3:0]  req_len;
  logic [2:0]  region;
  logic        rsp_valid;
  logic [63:0] rsp_data;
  logic        spi_sclk, spi_mosi, spi_miso, spi_cs_n;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  fw_flash_bridge #(.MAX_BYTES(8), .SCLK_HALF_CYC(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .region(region),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n));

  function automatic logic [7:0] fbyte(input logic [23:0] a);
    return (a[7:0] * 8'd29 + a[15:8]) ^ a[23:16] ^ 8'h5C;
  endfunction

  function automatic logic [2:0] exp_region(input logic [31:0] a);
    if (a >= 32'hFF00_0000)      return 3'd4;
    else if (a >= 32'hC000_0000) return 3'd3;
    else if (a >= 32'h0010_0000) return 3'd2;
    else if (a >= 32'h000A_0000) return 3'd1;
    return 3'd0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural flash: captures the header on rising edges, drives data on falling edges.
  int          rises = 0;
  int          sclk_rises_total = 0;
  int          cs_falls = 0;
  int          rsp_count = 0;
  logic [31:0] hdr = '0;
  logic        miso_r = 1'b0;
  logic [7:0]  cur_byte;
  int          dbit;
  assign spi_miso = miso_r;

  always @(negedge spi_cs_n) begin
    rises = 0;
    hdr = '0;
    cs_falls++;
  end

  always @(posedge spi_sclk) begin
    sclk_rises_total++;
    if (!spi_cs_n) begin
      if (rises < 32) hdr = {hdr[30:0], spi_mosi};
      rises++;
    end
  end

  always @(negedge spi_sclk) begin
    if (!spi_cs_n && rises >= 32) begin
      dbit = rises - 32;
      cur_byte = fbyte(hdr[23:0] + 24'(dbit / 8));
      miso_r = cur_byte[7 - (dbit % 8)];
    end
  end

  // Chip-select timing monitors (sampled values before each clock edge).
  int low_cnt = 0, last_low = 0, gap_cnt = 0, last_gap = 0;
  always @(posedge clk) begin
    if (rsp_valid) rsp_count++;
    if (spi_cs_n) gap_cnt++;
    else          low_cnt++;
  end
  always @(negedge spi_cs_n) begin
    last_gap = gap_cnt;
    low_cnt = 0;
  end
  always @(posedge spi_cs_n) begin
    last_low = low_cnt;
    gap_cnt = 0;
  end

  task automatic do_read(input logic [31:0] a, input logic [3:0] l, input int nb, input bit b2b);
    logic [63:0] exp;
    int cyc;
    bit ready_bad;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_len = l;
    #1;
    check(region == 3'd4, "R2 firmware region with valid", 64'(region), 64'd4);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R7 ready drops after accept", 64'(req_ready), 64'd0);
    cyc = 0; ready_bad = 1'b0;
    while (!rsp_valid && cyc < 2000) begin
      if (req_ready) ready_bad = 1'b1;
      @(negedge clk);
      cyc++;
    end
    check(!ready_bad, "R7 ready low during transfer", 64'(ready_bad), 64'd0);
    check(rsp_valid == 1'b1, "R7 response pulse seen", 64'(rsp_valid), 64'd1);
    check(spi_cs_n == 1'b1, "R7 cs released with pulse", 64'(spi_cs_n), 64'd1);
    exp = '0;
    for (int i = 0; i < nb; i++) exp[i*8 +: 8] = fbyte(a[23:0] + 24'(i));
    check(rsp_data == exp, $sformatf("R6 data addr=%0h len=%0d", a, l), rsp_data, exp);
    check(hdr[31:24] == 8'h03, "R3 opcode", 64'(hdr[31:24]), 64'h03);
    check(hdr[23:0] == a[23:0], "R3 address bytes", 64'(hdr[23:0]), 64'(a[23:0]));
    check(rises == 32 + 8*nb, $sformatf("R5 sclk edges len=%0d", l), 64'(rises), 64'(32 + 8*nb));
    check(last_low == 2*HALF*(32 + 8*nb), "R4 cs low duration", 64'(last_low), 64'(2*HALF*(32 + 8*nb)));
    if (b2b) check(last_gap >= 2*HALF, "R9 cs idle gap", 64'(last_gap), 64'(2*HALF));
    @(negedge clk);
    check(rsp_valid == 1'b0, "R7 pulse one cycle", 64'(rsp_valid), 64'd0);
  endtask

  task automatic non_fw(input logic [31:0] a);
    int f0, s0, r0;
    bit rdy_bad;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    f0 = cs_falls; s0 = sclk_rises_total; r0 = rsp_count;
    req_valid = 1'b1; req_addr = a; req_len = 4'd8;
    #1;
    check(region == exp_region(a), "R1 region of non-firmware request", 64'(region), 64'(exp_region(a)));
    @(negedge clk);
    req_valid = 1'b0;
    rdy_bad = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (!req_ready || !spi_cs_n) rdy_bad = 1'b1;
      @(negedge clk);
    end
    check(!rdy_bad, "R8 ready high and cs idle", 64'(rdy_bad), 64'd0);
    check(cs_falls == f0 && sclk_rises_total == s0, "R8 no serial activity",
          64'(cs_falls - f0 + sclk_rises_total - s0), 64'd0);
    check(rsp_count == r0, "R8 no response", 64'(rsp_count - r0), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] bnd_a [10];
    logic [2:0]  bnd_e [10];
    logic [31:0] a;
    bnd_a = '{32'h0000_0000, 32'h0009_FFFF, 32'h000A_0000, 32'h000F_FFFF, 32'h0010_0000,
              32'hBFFF_FFFF, 32'hC000_0000, 32'hFEFF_FFFF, 32'hFF00_0000, 32'hFFFF_FFFF};
    bnd_e = '{3'd0, 3'd0, 3'd1, 3'd1, 3'd2, 3'd2, 3'd3, 3'd3, 3'd4, 3'd4};
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_len = 4'd1;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1 && spi_cs_n == 1'b1 && spi_sclk == 1'b0 && rsp_valid == 1'b0,
          "R10 reset outputs", {60'd0, req_ready, spi_cs_n, spi_sclk, rsp_valid}, 64'b1100);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 boundaries with hand-written codes.
    for (int i = 0; i < 10; i++) begin
      req_addr = bnd_a[i];
      #1;
      check(region == bnd_e[i], $sformatf("R1 boundary %0h", bnd_a[i]), 64'(region), 64'(bnd_e[i]));
      @(negedge clk);
    end
    // R1/R2 sweep of the top 12 bits with req_valid low.
    for (int i = 0; i < 4096; i++) begin
      a = {i[11:0], 20'h0} | ((32'(i) * 32'h9E37) & 32'h000F_FFFF);
      req_addr = a;
      #1;
      check(region == exp_region(a), $sformatf("R2 sweep %0h", a), 64'(region), 64'(exp_region(a)));
      @(negedge clk);
    end

    // R3/R5/R6: every legal length at the reset vector, then clamped lengths.
    for (int l = 1; l <= 8; l++) do_read(32'hFFFF_FFF0, 4'(l), l, 1'b0);
    do_read(32'hFF12_3456, 4'd0, 1, 1'b0);
    do_read(32'hFFAB_CDEF, 4'd12, 8, 1'b0);
    do_read(32'hFF00_0000, 4'd8, 8, 1'b0);
    // R9: back-to-back transactions.
    do_read(32'hFF5A_A5C3, 4'd3, 3, 1'b1);
    do_read(32'hFFFF_FFFC, 4'd5, 5, 1'b1);

    // R8: one address in each other region.
    non_fw(32'h0000_1234);
    non_fw(32'h000B_8000);
    non_fw(32'h1234_5678);
    non_fw(32'hFEFF_FFFF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule